// File: doc/BRIEF.md
# Disk Device Status Register Logic

This block forms the device-side status byte of a disk task-file interface. It registers the condition lines of the drive (busy, ready, write fault, seek done, data request, error and the once-per-revolution index pulse) and packs them into one 8-bit byte. It answers host reads that arrive as an address, a read strobe and a combinational data bus.

The block keeps a pending-interrupt flag. A command-complete pulse sets it. A read of the primary status address acknowledges it. A second address, the alternate status address, returns the same byte but has no side effects.

When a command completes with an error, the ready, write-fault and seek-done bits are frozen until the host reads primary status. While the device is busy, a read of any command-block address returns the status byte. After busy falls, a programmable number of cycles must pass before any bit other than busy is shown.

Top module: `dsk_status_regs`

## Requirements
- R1: The status byte is laid out from bit 7 to bit 0 as busy, ready, write fault, seek done, data request, corrected (constant 1), index, error. When the byte is valid, bit 2 always reads 1.
- R2: Ready, seek done, data request, index and busy show the input value sampled at the previous rising clock edge. Ready reads 0 after reset until dev_ready is seen high.
- R3: Error (bit 0) and write fault (bit 5) are captured only at an edge where cmd_done is high. A change of dev_err or dev_wfault at any other time leaves them unchanged.
- R4: After cmd_done with dev_err high, the ready and seek-done bits keep the values captured at that edge. They stay frozen until an edge where a primary status read is accepted. From the next edge on they follow their inputs again.
- R5: intrq rises one edge after cmd_done. It falls one edge after a primary status read (rd_stb high, rd_addr = 7). If cmd_done arrives at the same edge as that read, intrq stays high.
- R6: A read of the alternate address (rd_addr = 14) returns the status byte. It neither clears intrq nor releases frozen bits.
- R7: While the busy bit is 1, a read of any command-block address (0 to 7) returns the status byte. While busy is 0, addresses 0 to 6 return cmd_reg_data.
- R8: While busy is 1, bits 6 to 0 read 0. After busy falls they stay 0 for SETTLE_CYC edges and then show the status.
- R9: After reset, intrq is 0 and the status byte reads 8'h04.

Parameters: SETTLE_CYC, ADDR_W, STAT_ADDR, ALT_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_busy | input | 1 | Device busy condition |
| dev_ready | input | 1 | Device can accept commands |
| dev_wfault | input | 1 | Write fault of the completing command |
| dev_seekdone | input | 1 | Head is on the target track |
| dev_datareq | input | 1 | Device ready to transfer data |
| dev_err | input | 1 | Completing command ended in error |
| index_pulse | input | 1 | Once-per-revolution index mark |
| cmd_done | input | 1 | Command-complete pulse |
| rd_stb | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host register address |
| cmd_reg_data | input | 8 | Contents of the addressed command-block register |
| rd_data | output | 8 | Read data |
| intrq | output | 1 | Pending interrupt |

## Verification
The hardest state to reach is a frozen status byte whose live inputs have since moved. The bench raises ready and seek-done and completes a command with an error. It then drops both inputs and reads the alternate address to show that the byte has not moved. Only then does it issue the primary read, and one edge later it checks that the bits follow their inputs again. A second scenario puts a command completion on the same edge as the acknowledging read. The settle window is walked one edge at a time so that the last masked cycle and the first valid cycle are each checked.

// File: rtl/dsk_stat_pkg.sv
package dsk_stat_pkg;

  // Packed order is bit 7 down to bit 0
  typedef struct packed {
    logic bsy;
    logic drdy;
    logic dwf;
    logic dsc;
    logic drq;
    logic corr;
    logic idx;
    logic err;
  } stat_t;

  // Hide all but busy while the byte is not yet valid
  function automatic logic [7:0] mask_status(stat_t s, logic valid);
    return valid ? 8'(s) : {s.bsy, 7'b0};
  endfunction

  // Width of a down-counter able to hold n
  function automatic int cnt_width(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dsk_settle_timer.sv
module dsk_settle_timer
  import dsk_stat_pkg::*;
#(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_q,
  output logic valid
);
  localparam int CW = cnt_width(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (busy_q)         cnt_q <= CW'(SETTLE_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign valid = !busy_q && (cnt_q == '0);

  // R8
  settle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SETTLE_CYC > 0 && $fell(busy_q)) |-> !valid);
  // R8
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SETTLE_CYC));
endmodule

// File: rtl/dsk_cond_sampler.sv
module dsk_cond_sampler
  import dsk_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dev_busy,
  input  logic  dev_ready,
  input  logic  dev_wfault,
  input  logic  dev_seekdone,
  input  logic  dev_datareq,
  input  logic  dev_err,
  input  logic  index_pulse,
  input  logic  cmd_done,
  input  logic  ack,
  output stat_t stat,
  output logic  frozen
);
  logic busy_q, drdy_q, dwf_q, dsc_q, drq_q, idx_q, err_q, frz_q;
  logic err_done, hold;

  assign err_done = cmd_done && dev_err;
  assign hold     = frz_q && !ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; drdy_q <= 1'b0; dwf_q <= 1'b0; dsc_q <= 1'b0;
      drq_q  <= 1'b0; idx_q  <= 1'b0; err_q <= 1'b0; frz_q <= 1'b0;
    end else begin
      busy_q <= dev_busy;
      drq_q  <= dev_datareq;
      idx_q  <= index_pulse;
      if (!hold) begin
        drdy_q <= dev_ready;
        dsc_q  <= dev_seekdone;
      end
      if (cmd_done) begin
        err_q <= dev_err;
        if (!hold) dwf_q <= dev_wfault;
      end
      if (err_done)  frz_q <= 1'b1;
      else if (ack)  frz_q <= 1'b0;
    end
  end

  assign stat   = '{bsy: busy_q, drdy: drdy_q, dwf: dwf_q, dsc: dsc_q,
                    drq: drq_q, corr: 1'b1, idx: idx_q, err: err_q};
  assign frozen = frz_q;

  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !ack) |=> ($stable(drdy_q) && $stable(dsc_q) && $stable(dwf_q)));
  // R4
  freeze_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_done |=> frz_q);
  // R3
  err_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done |=> $stable(err_q));
endmodule

// File: rtl/dsk_irq_track.sv
module dsk_irq_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_done,
  input  logic ack,
  output logic intrq
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (cmd_done) pend_q <= 1'b1;
    else if (ack)      pend_q <= 1'b0;
  end

  assign intrq = pend_q;

  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> intrq);
  // R5
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cmd_done) |=> !intrq);
  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !cmd_done) |=> $stable(intrq));
endmodule

// File: rtl/dsk_status_regs.sv
module dsk_status_regs
  import dsk_stat_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  parameter int ADDR_W     = 4,
  parameter int STAT_ADDR  = 7,
  parameter int ALT_ADDR   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_busy,
  input  logic              dev_ready,
  input  logic              dev_wfault,
  input  logic              dev_seekdone,
  input  logic              dev_datareq,
  input  logic              dev_err,
  input  logic              index_pulse,
  input  logic              cmd_done,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        cmd_reg_data,
  output logic [7:0]        rd_data,
  output logic              intrq
);
  localparam int CMDBLK_REGS = 8;

  stat_t       stat;
  logic        frozen, valid, ack, is_stat, is_alt, is_cmdblk;
  logic [7:0]  shown;

  assign is_stat   = (rd_addr == ADDR_W'(STAT_ADDR));
  assign is_alt    = (rd_addr == ADDR_W'(ALT_ADDR));
  assign is_cmdblk = (rd_addr <  ADDR_W'(CMDBLK_REGS));
  assign ack       = rd_stb && is_stat;

  dsk_cond_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .dev_busy(dev_busy), .dev_ready(dev_ready),
    .dev_wfault(dev_wfault), .dev_seekdone(dev_seekdone),
    .dev_datareq(dev_datareq), .dev_err(dev_err), .index_pulse(index_pulse),
    .cmd_done(cmd_done), .ack(ack), .stat(stat), .frozen(frozen));

  dsk_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .busy_q(stat.bsy), .valid(valid));

  dsk_irq_track u_irq (
    .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .ack(ack), .intrq(intrq));

  assign shown = mask_status(stat, valid);

  always_comb begin
    if (is_stat || is_alt)  rd_data = shown;
    else if (is_cmdblk)     rd_data = stat.bsy ? shown : cmd_reg_data;
    else                    rd_data = 8'h00;
  end

  // R7
  busy_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.bsy && is_cmdblk) |-> (rd_data == shown));
  // R6
  alt_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_alt |-> (rd_data == shown));
  // R8
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.bsy && (is_stat || is_alt)) |-> (rd_data[6:0] == 7'b0));
  // R1
  corr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_stat) |-> rd_data[2]);
  // R6
  alt_no_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !cmd_done && rd_stb && is_alt) |=> frozen);
endmodule

// File: tb/test_dsk_status_regs.sv
module test_dsk_status_regs;
  localparam int SETTLE = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dev_busy = 0, dev_ready = 0, dev_wfault = 0, dev_seekdone = 0;
  logic dev_datareq = 0, dev_err = 0, index_pulse = 0, cmd_done = 0, rd_stb = 0;
  logic [3:0] rd_addr = 4'd7;
  logic [7:0] cmd_reg_data = 8'hA5;
  logic [7:0] rd_data;
  logic intrq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dsk_status_regs #(.SETTLE_CYC(SETTLE)) i_dsk_status_regs (
    .clk(clk), .rst_n(rst_n), .dev_busy(dev_busy), .dev_ready(dev_ready),
    .dev_wfault(dev_wfault), .dev_seekdone(dev_seekdone),
    .dev_datareq(dev_datareq), .dev_err(dev_err), .index_pulse(index_pulse),
    .cmd_done(cmd_done), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .cmd_reg_data(cmd_reg_data), .rd_data(rd_data), .intrq(intrq));

  // Expected byte built from named fields
  function automatic logic [7:0] mk(bit b, bit rdy, bit wf, bit sk, bit dq, bit ix, bit er);
    return (b ? 8'h80 : 8'h00) | (rdy ? 8'h40 : 8'h00) | (wf ? 8'h20 : 8'h00) |
           (sk ? 8'h10 : 8'h00) | (dq ? 8'h08 : 8'h00) | 8'h04 |
           (ix ? 8'h02 : 8'h00) | (er ? 8'h01 : 8'h00);
  endfunction

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  // Advance one edge, land mid-low phase
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] d);
    rd_addr = a; #0.1; d = rd_data;
  endtask

  task automatic strobe(logic [3:0] a);
    rd_addr = a; rd_stb = 1; step(); rd_stb = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(4'd7, d);
    chk("R9", "reset status", d, 8'h04);
    chk("R9", "reset intrq", {7'b0, intrq}, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    dev_ready = 1; dev_seekdone = 1; dev_datareq = 1; index_pulse = 1;
    peek(4'd7, d);
    chk("R2", "before edge", d, 8'h04);
    step();
    peek(4'd7, d);
    chk("R1", "layout", d, mk(0, 1, 0, 1, 1, 1, 0));
    index_pulse = 0; dev_datareq = 0; step();
    peek(4'd7, d);
    chk("R2", "idx/drq drop", d, mk(0, 1, 0, 1, 0, 0, 0));
  endtask

  task automatic t_busy();
    logic [7:0] d;
    dev_busy = 1; step();
    peek(4'd3, d);
    chk("R7", "busy alias", d, 8'h80);
    peek(4'd7, d);
    chk("R8", "busy mask", d, 8'h80);
    dev_busy = 0; step();
    peek(4'd3, d);
    chk("R7", "passthrough", d, 8'hA5);
    for (int k = 0; k < SETTLE - 1; k++) step();
    peek(4'd7, d);
    chk("R8", "last masked", d, 8'h00);
    step();
    peek(4'd7, d);
    chk("R8", "first valid", d, mk(0, 1, 0, 1, 0, 0, 0));
  endtask

  task automatic t_irq();
    cmd_done = 1; step(); cmd_done = 0;
    chk("R5", "irq set", {7'b0, intrq}, 8'h01);
    strobe(4'd14);
    chk("R6", "alt keeps irq", {7'b0, intrq}, 8'h01);
    strobe(4'd7);
    chk("R5", "irq ack", {7'b0, intrq}, 8'h00);
    cmd_done = 1; step(); cmd_done = 0;
    rd_addr = 4'd7; rd_stb = 1; cmd_done = 1; step(); rd_stb = 0; cmd_done = 0;
    chk("R5", "done wins over ack", {7'b0, intrq}, 8'h01);
    strobe(4'd7);
  endtask

  task automatic t_freeze();
    logic [7:0] d;
    dev_err = 1; step();
    peek(4'd7, d);
    chk("R3", "err no done", d, mk(0, 1, 0, 1, 0, 0, 0));
    dev_wfault = 1; cmd_done = 1; step(); cmd_done = 0; dev_err = 0; dev_wfault = 0;
    peek(4'd7, d);
    chk("R3", "err captured", d, mk(0, 1, 1, 1, 0, 0, 1));
    dev_ready = 0; dev_seekdone = 0; step(); step();
    peek(4'd7, d);
    chk("R4", "frozen", d, mk(0, 1, 1, 1, 0, 0, 1));
    strobe(4'd14);
    peek(4'd14, d);
    chk("R6", "alt no release", d, mk(0, 1, 1, 1, 0, 0, 1));
    strobe(4'd7);
    peek(4'd7, d);
    chk("R4", "released", d, mk(0, 0, 1, 0, 0, 0, 1));
    dev_ready = 1; step();
    peek(4'd7, d);
    chk("R4", "tracks again", d, mk(0, 1, 1, 0, 0, 0, 1));
    cmd_done = 1; step(); cmd_done = 0;
    peek(4'd7, d);
    chk("R3", "err cleared at done", d, mk(0, 1, 0, 0, 0, 0, 0));
    strobe(4'd7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #1;
    t_reset();
    t_layout();
    t_busy();
    t_irq();
    t_freeze();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule